// File: doc/BRIEF.md
# Radio Module Power Sequencer

This block sits on the host side of a board and drives the four control lines of an external radio module: the battery-rail enable, the I/O-rail enable, the chip enable and the active-low module reset. The host holds one level input, `pwr_req`. Raising it starts the power-up order: battery rail, then I/O rail, then chip enable, and finally reset release after an oscillator-settling wait. Dropping it runs the teardown in the mirrored order.

Every wait is counted in clock cycles. The settling wait is given in microseconds and is converted through a clock-frequency parameter, rounded up to whole cycles. The short gaps between the rail steps are a separate cycle-count parameter. A withdrawn request during power-up, including one that arrives during the settling wait, leaves the ramp at once and enters the teardown. A renewed request during teardown waits until the module is fully off and then starts a fresh power-up. `busy` marks a sequence in progress and `ready` marks a module out of reset.

Top module: `power_sequencer`

## Requirements
- R1: The I/O-rail enable never rises while the battery-rail enable is low. On power-up the battery rail rises first, and the I/O rail follows exactly `STEP_CYC` cycles later.
- R2: Chip enable rises only while the I/O rail is already on, exactly `STEP_CYC` cycles after the I/O rail rises.
- R3: Reset is released (`rst_n` goes to 1) exactly ceil(`CLK_HZ` x `SETTLE_US` / 1e6) cycles after chip enable rises, and never earlier.
- R4: On power-down, chip enable and `rst_n` fall in the same cycle. The I/O rail falls `STEP_CYC` cycles later, so neither of the two is ever high without the I/O rail.
- R5: The battery rail falls `STEP_CYC` cycles after the I/O rail and never while the I/O rail is on.
- R6: While `rst` is high, and in the cycle after it, all four control outputs are driven low (no unknown value), and `busy` and `ready` are low.
- R7: A request withdrawn during the settling wait drops chip enable in the next cycle without ever releasing reset, and then completes the teardown of R4 and R5.
- R8: `busy` is 1 while a power-up or power-down is in progress and 0 when fully off or fully on. `ready` is 1 exactly while `rst_n` is 1. The two are never both high.
- R9: A request raised during teardown is ignored until the battery rail has fallen. The battery rail then rises again in the cycle after it fell.
- R10: The battery rail stays on alone for exactly `STEP_CYC` cycles before the I/O rail rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_req | input | 1 | Level request: 1 = module powered, 0 = module off |
| batt_en | output | 1 | Battery-rail enable |
| io_en | output | 1 | I/O-rail enable |
| chip_en | output | 1 | Module chip enable |
| rst_n | output | 1 | Module reset, active low (1 = released) |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | Module out of reset |

## Verification
The sequencer is driven with a clean ramp and a clean teardown, which measure every inter-edge gap against `STEP_CYC` and the rounded settling count. A clock frequency that does not divide evenly exposes a truncating conversion. A request dropped midway through the settling wait separates a clean abort from a design that lets reset slip out or leaves the rails in the wrong order. A request renewed during teardown separates "finish the teardown, then restart" from an early reversal that would raise a rail while the others are still coming down.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        PS_OFF     = 3'd0,
        PS_BATT    = 3'd1,
        PS_IO      = 3'd2,
        PS_CHIP    = 3'd3,
        PS_RUN     = 3'd4,
        PS_CORE_DN = 3'd5,
        PS_IO_DN   = 3'd6
    } pstate_e;

    typedef struct packed {
        logic batt;
        logic io;
        logic chip;
        logic rel;
    } rails_t;

    // Whole cycles covering a wait in microseconds, rounded up.
    function automatic int unsigned ceil_cycles(input longint unsigned hz,
                                                input longint unsigned us);
        longint unsigned prod;
        prod = hz * us;
        return int'((prod + 64'd999_999) / 64'd1_000_000);
    endfunction

    // Rail levels that each state holds.
    function automatic rails_t rails_of(input pstate_e s);
        rails_t r;
        r = '0;
        case (s)
            PS_BATT:    r = '{batt: 1'b1, io: 1'b0, chip: 1'b0, rel: 1'b0};
            PS_IO:      r = '{batt: 1'b1, io: 1'b1, chip: 1'b0, rel: 1'b0};
            PS_CHIP:    r = '{batt: 1'b1, io: 1'b1, chip: 1'b1, rel: 1'b0};
            PS_RUN:     r = '{batt: 1'b1, io: 1'b1, chip: 1'b1, rel: 1'b1};
            PS_CORE_DN: r = '{batt: 1'b1, io: 1'b1, chip: 1'b0, rel: 1'b0};
            PS_IO_DN:   r = '{batt: 1'b1, io: 1'b0, chip: 1'b0, rel: 1'b0};
            default:    r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    // Counter saturates one below the limit; the state holds for 'limit' cycles.
    assign expired = (cnt + CNT_W'(1)) >= limit;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int STEP_CYC   = 4,
    parameter int SETTLE_CYC = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             expired,
    output pstate_e          state,
    output logic             tmr_clr,
    output logic [CNT_W-1:0] limit
);

    pstate_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            PS_OFF:     if (req) nxt = PS_BATT;
            PS_BATT:    if (!req) nxt = PS_IO_DN;
                        else if (expired) nxt = PS_IO;
            PS_IO:      if (!req) nxt = PS_CORE_DN;
                        else if (expired) nxt = PS_CHIP;
            PS_CHIP:    if (!req) nxt = PS_CORE_DN;
                        else if (expired) nxt = PS_RUN;
            PS_RUN:     if (!req) nxt = PS_CORE_DN;
            PS_CORE_DN: if (expired) nxt = PS_IO_DN;
            PS_IO_DN:   if (expired) nxt = PS_OFF;
            default:    nxt = PS_OFF;
        endcase
    end

    assign tmr_clr = (nxt != state);
    assign limit   = (state == PS_CHIP) ? CNT_W'(SETTLE_CYC) : CNT_W'(STEP_CYC);

    always_ff @(posedge clk) begin
        if (rst) state <= PS_OFF;
        else     state <= nxt;
    end

    // R7
    abort_settle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PS_CHIP && !req) |=> (state == PS_CORE_DN));

    // R9
    teardown_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PS_CORE_DN && !expired) |=> (state == PS_CORE_DN));

endmodule

// File: rtl/power_sequencer.sv
module power_sequencer
    import pwrseq_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 125_000_000,
    parameter int unsigned SETTLE_US = 5000,
    parameter int          STEP_CYC  = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_req,
    output logic batt_en,
    output logic io_en,
    output logic chip_en,
    output logic rst_n,
    output logic busy,
    output logic ready
);

    localparam int SETTLE_CYC = int'(ceil_cycles(longint'(CLK_HZ), longint'(SETTLE_US)));
    localparam int MAX_WAIT   = (SETTLE_CYC > STEP_CYC) ? SETTLE_CYC : STEP_CYC;
    localparam int CNT_W      = $clog2(MAX_WAIT + 1) + 1;

    pstate_e          state;
    logic             tmr_clr;
    logic             expired;
    logic [CNT_W-1:0] limit;
    rails_t           rails;

    pwrseq_fsm #(
        .CNT_W     (CNT_W),
        .STEP_CYC  (STEP_CYC),
        .SETTLE_CYC(SETTLE_CYC)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .req    (pwr_req),
        .expired(expired),
        .state  (state),
        .tmr_clr(tmr_clr),
        .limit  (limit)
    );

    pwrseq_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr    (tmr_clr),
        .limit  (limit),
        .expired(expired)
    );

    assign rails   = rails_of(state);
    assign batt_en = rails.batt;
    assign io_en   = rails.io;
    assign chip_en = rails.chip;
    assign rst_n   = rails.rel;
    assign busy    = (state != PS_OFF) && (state != PS_RUN);
    assign ready   = (state == PS_RUN);

    // Cycles chip enable has been high, saturating at the settling count.
    logic [CNT_W-1:0] ce_age;
    always_ff @(posedge clk) begin
        if (rst || !chip_en)                ce_age <= '0;
        else if (ce_age != CNT_W'(SETTLE_CYC)) ce_age <= ce_age + CNT_W'(1);
    end

    // R1
    io_after_batt_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(io_en) |-> $past(batt_en));

    // R2
    chip_after_io_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(chip_en) |-> $past(io_en));

    // R3
    settle_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_n) |-> (ce_age >= CNT_W'(SETTLE_CYC)));

    // R4
    core_before_io_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(io_en) |-> (!chip_en && !rst_n));

    // R4
    chip_rst_together_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(chip_en) |-> $fell(rst_n) || !$past(rst_n));

    // R5
    batt_after_io_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(batt_en) |-> !io_en);

    // R6
    reset_off_chk: assert property (@(posedge clk)
        rst |=> (!batt_en && !io_en && !chip_en && !rst_n && !busy && !ready));

    // R8
    busy_ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && ready));

endmodule

// File: tb/tb_power_sequencer.sv
module tb_power_sequencer;

    localparam int unsigned CLK_HZ    = 1_000_003;
    localparam int unsigned SETTLE_US = 5000;
    localparam int          STEP      = 3;
    localparam longint      SETTLE_EXP = (longint'(CLK_HZ) * longint'(SETTLE_US) + 999_999) / 1_000_000;
    localparam int          UP_WAIT   = 2 * STEP + int'(SETTLE_EXP) + 6;
    localparam int          DN_WAIT   = 2 * STEP + 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_req = 1'b0;
    logic batt_en, io_en, chip_en, rst_n, busy, ready;

    always #4 clk = ~clk;

    power_sequencer #(
        .CLK_HZ   (CLK_HZ),
        .SETTLE_US(SETTLE_US),
        .STEP_CYC (STEP)
    ) dut (
        .clk    (clk),
        .rst    (rst),
        .pwr_req(pwr_req),
        .batt_en(batt_en),
        .io_en  (io_en),
        .chip_en(chip_en),
        .rst_n  (rst_n),
        .busy   (busy),
        .ready  (ready)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Edge-time monitor on the falling clock edge.
    int cyc = 0;
    logic pb = 0, pi = 0, pc = 0, pr = 0;
    int rb = 0, fb = 0, ri = 0, fi = 0, rc = 0, fc = 0, rr = 0, fr = 0;
    int n_rel = 0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (batt_en === 1'b1 && !pb) rb = cyc;
        if (batt_en === 1'b0 &&  pb) fb = cyc;
        if (io_en   === 1'b1 && !pi) ri = cyc;
        if (io_en   === 1'b0 &&  pi) fi = cyc;
        if (chip_en === 1'b1 && !pc) rc = cyc;
        if (chip_en === 1'b0 &&  pc) fc = cyc;
        if (rst_n   === 1'b1 && !pr) begin rr = cyc; n_rel = n_rel + 1; end
        if (rst_n   === 1'b0 &&  pr) fr = cyc;
        pb = (batt_en === 1'b1);
        pi = (io_en === 1'b1);
        pc = (chip_en === 1'b1);
        pr = (rst_n === 1'b1);
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle(3);
        // R6: all control lines driven low, no unknown value
        chk(!$isunknown({batt_en, io_en, chip_en, rst_n}), "R6 known", {batt_en, io_en, chip_en, rst_n}, 0);
        chk({batt_en, io_en, chip_en, rst_n} == 4'b0000, "R6 rails low", {batt_en, io_en, chip_en, rst_n}, 0);
        chk(!busy && !ready, "R6 status low", {busy, ready}, 0);
        rst = 1'b0;
        idle(1);
        chk({batt_en, io_en, chip_en, rst_n} == 4'b0000, "R6 after reset", {batt_en, io_en, chip_en, rst_n}, 0);
    endtask

    task automatic t_up();
        pwr_req = 1'b1;
        idle(STEP + 1);
        // R8: busy during the ramp
        chk(busy === 1'b1 && ready === 1'b0, "R8 busy in ramp", {busy, ready}, 2);
        idle(UP_WAIT - STEP - 1);
        chk(ri - rb == STEP, "R10 battery-alone gap", ri - rb, STEP);
        chk(ri >= rb, "R1 io after battery", ri, rb);
        chk(rc - ri == STEP, "R2 chip after io", rc - ri, STEP);
        chk(rr - rc == SETTLE_EXP, "R3 settling gap", rr - rc, SETTLE_EXP);
        chk(ready === 1'b1 && busy === 1'b0, "R8 ready when on", {busy, ready}, 1);
        chk(rst_n === 1'b1 && chip_en === 1'b1, "R3 released", {chip_en, rst_n}, 3);
    endtask

    task automatic t_down();
        pwr_req = 1'b0;
        idle(DN_WAIT);
        chk(fc == fr, "R4 chip and reset together", fc, fr);
        chk(fi - fc == STEP, "R4 io after core", fi - fc, STEP);
        chk(fb - fi == STEP, "R5 battery after io", fb - fi, STEP);
        chk({batt_en, io_en, chip_en, rst_n} == 4'b0000, "R5 all off", {batt_en, io_en, chip_en, rst_n}, 0);
        chk(busy === 1'b0 && ready === 1'b0, "R8 idle when off", {busy, ready}, 0);
    endtask

    task automatic t_abort();
        int rel0;
        pwr_req = 1'b1;
        idle(2 * STEP + 100);
        chk(chip_en === 1'b1 && rst_n === 1'b0, "R7 in settling wait", {chip_en, rst_n}, 2);
        rel0 = n_rel;
        pwr_req = 1'b0;
        idle(1);
        // R7: chip enable drops in the next cycle
        chk(chip_en === 1'b0, "R7 chip drops at once", chip_en, 0);
        idle(DN_WAIT);
        chk(n_rel == rel0, "R7 reset never released", n_rel, rel0);
        chk(fi - fc == STEP, "R7 io after chip", fi - fc, STEP);
        chk(fb - fi == STEP, "R7 battery after io", fb - fi, STEP);
        chk({batt_en, io_en, chip_en, rst_n} == 4'b0000, "R7 all off", {batt_en, io_en, chip_en, rst_n}, 0);
    endtask

    task automatic t_reissue();
        int fb0;
        t_up();
        fb0 = fb;
        pwr_req = 1'b0;
        idle(STEP + 1);
        // R9: request renewed mid-teardown
        pwr_req = 1'b1;
        chk(io_en === 1'b0 && batt_en === 1'b1, "R9 mid teardown", {batt_en, io_en}, 2);
        idle(STEP + 4);
        chk(fb != fb0, "R9 battery fell first", fb, fb0 + 1);
        chk(rb - fb == 1, "R9 restart after off", rb - fb, 1);
        idle(UP_WAIT);
        chk(ready === 1'b1, "R9 ramp completes", ready, 1);
        t_down();
    endtask

    initial begin
        t_reset();
        t_up();
        t_down();
        t_abort();
        t_reissue();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100_000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule